// File: doc/BRIEF.md
# Remote-Terminal Command Decoder and Status Flag Unit

This unit sits behind the Manchester decoder of a MIL-STD-1553 remote terminal. Each received 16-bit command word arrives with a one-cycle strobe. The unit compares the word's terminal address against a strapped five-bit address that carries its own parity bit. When the command is for this terminal, or is a broadcast and broadcasts are enabled, the unit opens a command window. While the window is open it holds the transmit/receive bit, the subaddress and the word-count field of that command.

Within the window, a running counter advances once for each transferred data word. A five-bit word-count output shows either that counter or the latched field. The choice depends on the window state and on whether the command is a mode command. The unit also keeps the message-error, service-request and dynamic-bus-acceptance flags of the status word. It samples these from active-low subsystem inputs at fixed moments. All registers reset synchronously on an active-high reset.

Top module: `rt_cmd_decode`

## Requirements
- R1: `addr_err_n` is low exactly when the five strapped address bits together with `own_par` hold an even number of ones; odd parity is the valid setting.
- R2: A strobed command whose bits 15:11 equal `own_addr` is accepted when the strap parity is valid: one cycle later `in_cmd` and `respond` are high and `bcast` is low. If the strap parity is invalid, the same command is ignored and `respond` never rises.
- R3: With `bcast_en` high, a command address of 31 is accepted as a broadcast even when the strap parity is invalid: `in_cmd` and `bcast` rise and `respond` stays low.
- R4: With `bcast_en` low, a command address of 31 is ignored unless `own_addr` is 31 with valid parity, in which case it is answered as an own-address command.
- R5: On acceptance, bit 10 (transmit/receive), bits 9:5 (subaddress) and bits 4:0 (word count/mode code) are latched. They stay unchanged through ignored commands and after the window closes, until the next accepted command.
- R6: `mode_cmd` is high when the latched subaddress is 0 or 31.
- R7: `wc_out` shows the latched word-count field when `in_cmd` is low or the command is a mode command. Otherwise it shows the low five bits of the running word counter.
- R8: The counter clears on every accepted command. It advances by one on each `word_done` while `in_cmd` is high and the command is not a mode command. If an acceptance and a `word_done` fall in the same cycle, the clear wins.
- R9: `all_words` is high when the counter has reached the commanded count of a non-mode command, with field value 0 meaning 32 words. Further `word_done` pulses leave the counter unchanged.
- R10: `msg_end` closes the window and clears `respond` and `bcast`. If an acceptance falls in the same cycle as `msg_end`, the acceptance wins.
- R11: `illegal_n` is sampled on the edge that accepts a command (the rising edge of the window). `msg_err` becomes its inverse and holds until the next acceptance.
- R12: On `status_upd`, `svc_req` takes the inverse of `svc_req_n`. Without `status_upd`, changes on `svc_req_n` have no effect.
- R13: On `status_upd`, `dbc_acc` is set only if `dbc_accept_n` is low and an open window holds a legal dynamic-bus-control command: a mode command, transmit bit 1, mode code 0, and `msg_err` low. Otherwise the update clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle strobe: `cmd_word` holds a received command |
| cmd_word | input | 16 | Command word: 15:11 address, 10 T/R, 9:5 subaddress, 4:0 count/code |
| own_addr | input | 5 | Strapped terminal address |
| own_par | input | 1 | Strapped parity bit for the address |
| bcast_en | input | 1 | High: address 31 is a broadcast |
| word_done | input | 1 | Pulse per transferred data word |
| msg_end | input | 1 | Pulse closing the command window |
| status_upd | input | 1 | Pulse: status word is being updated |
| illegal_n | input | 1 | Active-low illegal-command mark |
| svc_req_n | input | 1 | Active-low service request |
| dbc_accept_n | input | 1 | Active-low bus-control acceptance |
| in_cmd | output | 1 | Command window open |
| respond | output | 1 | Terminal must reply with status |
| bcast | output | 1 | Current command is a broadcast |
| sub_addr | output | 5 | Latched subaddress |
| tx_rx | output | 1 | Latched transmit/receive bit |
| wc_out | output | 5 | Latched count field or running counter |
| mode_cmd | output | 1 | Latched command is a mode command |
| all_words | output | 1 | Commanded word count reached |
| addr_err_n | output | 1 | Low on strap parity error |
| msg_err | output | 1 | Status message-error flag |
| svc_req | output | 1 | Status service-request flag |
| dbc_acc | output | 1 | Status bus-control-acceptance flag |

## Verification
Two overlaps can occur in one cycle: a new accepted command together with a data-word pulse, and a new accepted command together with the end of a message. The bench raises `word_done` in the same cycle as `cmd_valid` while the counter is non-zero, and expects the counter to read zero. It also raises `msg_end` with an accepted command and expects the window to stay open with the new fields. A further case updates the status word in the cycle of a new acceptance, where the old latched command must decide the bus-control flag.

// File: rtl/rt_cmd_pkg.sv
package rt_cmd_pkg;

    localparam int ADDR_W = 5;
    localparam int SA_W   = 5;
    localparam int WC_W   = 5;
    localparam int CNT_W  = WC_W + 1;

    localparam logic [ADDR_W-1:0] BCAST_ADDR = '1;
    localparam logic [WC_W-1:0]   DBC_CODE   = '0;

    // Field order follows the bus word: address, T/R, subaddress, count/code.
    typedef struct packed {
        logic [ADDR_W-1:0] rt;
        logic              tr;
        logic [SA_W-1:0]   sa;
        logic [WC_W-1:0]   wc;
    } cmd_t;

    typedef struct packed {
        logic              tr;
        logic [SA_W-1:0]   sa;
        logic [WC_W-1:0]   wc;
    } fld_t;

    typedef struct packed {
        logic accept;
        logic own_hit;
        logic bcast;
    } decode_t;

    function automatic logic is_mode(input logic [SA_W-1:0] sa);
        return (sa == '0) || (sa == '1);
    endfunction

    // A count field of zero stands for the full range.
    function automatic logic [CNT_W-1:0] words_of(input logic [WC_W-1:0] wc);
        return (wc == '0) ? CNT_W'(1 << WC_W) : {1'b0, wc};
    endfunction

endpackage

// File: rtl/rt_addr_match.sv
module rt_addr_match
    import rt_cmd_pkg::*;
(
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] rt,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              own_par,
    input  logic              bcast_en,
    output logic              par_ok,
    output decode_t           dec
);
    logic is_b;
    logic is_own;

    always_comb begin
        par_ok      = ^{own_addr, own_par};
        is_b        = bcast_en && (rt == BCAST_ADDR);
        is_own      = par_ok && (rt == own_addr) && !is_b;
        dec.bcast   = cmd_valid && is_b;
        dec.own_hit = cmd_valid && is_own;
        dec.accept  = dec.bcast || dec.own_hit;
    end

endmodule

// File: rtl/rt_field_latch.sv
module rt_field_latch
    import rt_cmd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  decode_t         dec,
    input  fld_t            fld_in,
    input  logic            word_done,
    input  logic            msg_end,
    output logic            in_cmd,
    output logic            respond,
    output logic            bcast,
    output fld_t            fld,
    output logic            mode,
    output logic [WC_W-1:0] wc_out,
    output logic            all_words
);
    logic [CNT_W-1:0] cnt_q;
    logic             counting;

    always_comb begin
        mode      = is_mode(fld.sa);
        counting  = in_cmd && !mode;
        all_words = counting && (cnt_q == words_of(fld.wc));
        wc_out    = counting ? cnt_q[WC_W-1:0] : fld.wc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_cmd  <= 1'b0;
            respond <= 1'b0;
            bcast   <= 1'b0;
            fld     <= '0;
            cnt_q   <= '0;
        end else if (dec.accept) begin
            in_cmd  <= 1'b1;
            respond <= dec.own_hit;
            bcast   <= dec.bcast;
            fld     <= fld_in;
            cnt_q   <= '0;
        end else begin
            if (msg_end) begin
                in_cmd  <= 1'b0;
                respond <= 1'b0;
                bcast   <= 1'b0;
            end
            if (word_done && counting && !all_words)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_fields_held_R5: assert property (@(posedge clk) disable iff (rst)
        !dec.accept |=> $stable(fld));
    assert_count_clear_R8: assert property (@(posedge clk) disable iff (rst)
        dec.accept |=> (in_cmd && cnt_q == '0));
    assert_count_stops_R9: assert property (@(posedge clk) disable iff (rst)
        (all_words && !dec.accept) |=> $stable(cnt_q));
    assert_window_close_R10: assert property (@(posedge clk) disable iff (rst)
        (msg_end && !dec.accept) |=> !in_cmd);
    assert_bcast_silent_R3: assert property (@(posedge clk) disable iff (rst)
        bcast |-> !respond);

endmodule

// File: rtl/rt_status_flags.sv
module rt_status_flags
    import rt_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic illegal_n,
    input  logic status_upd,
    input  logic svc_req_n,
    input  logic dbc_accept_n,
    input  logic in_cmd,
    input  fld_t fld,
    output logic msg_err,
    output logic svc_req,
    output logic dbc_acc
);
    logic dbc_legal;

    always_comb
        dbc_legal = in_cmd && is_mode(fld.sa) && fld.tr &&
                    (fld.wc == DBC_CODE) && !msg_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_err <= 1'b0;
            svc_req <= 1'b0;
            dbc_acc <= 1'b0;
        end else begin
            if (accept)
                msg_err <= !illegal_n;
            if (status_upd) begin
                svc_req <= !svc_req_n;
                dbc_acc <= !dbc_accept_n && dbc_legal;
            end
        end
    end

    assert_illegal_sample_R11: assert property (@(posedge clk) disable iff (rst)
        (accept && !illegal_n) |=> msg_err);
    assert_svc_update_R12: assert property (@(posedge clk) disable iff (rst)
        status_upd |=> (svc_req == !$past(svc_req_n)));
    assert_svc_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !status_upd |=> $stable(svc_req));
    assert_dbc_source_R13: assert property (@(posedge clk) disable iff (rst)
        $rose(dbc_acc) |-> ($past(status_upd) && !$past(dbc_accept_n)));

endmodule

// File: rtl/rt_cmd_decode.sv
module rt_cmd_decode
    import rt_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [15:0] cmd_word,
    input  logic [4:0]  own_addr,
    input  logic        own_par,
    input  logic        bcast_en,
    input  logic        word_done,
    input  logic        msg_end,
    input  logic        status_upd,
    input  logic        illegal_n,
    input  logic        svc_req_n,
    input  logic        dbc_accept_n,
    output logic        in_cmd,
    output logic        respond,
    output logic        bcast,
    output logic [4:0]  sub_addr,
    output logic        tx_rx,
    output logic [4:0]  wc_out,
    output logic        mode_cmd,
    output logic        all_words,
    output logic        addr_err_n,
    output logic        msg_err,
    output logic        svc_req,
    output logic        dbc_acc
);
    cmd_t    cmd;
    fld_t    fld_in;
    fld_t    fld;
    decode_t dec;
    logic    par_ok;

    always_comb begin
        cmd    = cmd_t'(cmd_word);
        fld_in = '{tr: cmd.tr, sa: cmd.sa, wc: cmd.wc};
    end

    rt_addr_match u_match (
        .cmd_valid (cmd_valid),
        .rt        (cmd.rt),
        .own_addr  (own_addr),
        .own_par   (own_par),
        .bcast_en  (bcast_en),
        .par_ok    (par_ok),
        .dec       (dec)
    );

    rt_field_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .dec       (dec),
        .fld_in    (fld_in),
        .word_done (word_done),
        .msg_end   (msg_end),
        .in_cmd    (in_cmd),
        .respond   (respond),
        .bcast     (bcast),
        .fld       (fld),
        .mode      (mode_cmd),
        .wc_out    (wc_out),
        .all_words (all_words)
    );

    rt_status_flags u_flags (
        .clk          (clk),
        .rst          (rst),
        .accept       (dec.accept),
        .illegal_n    (illegal_n),
        .status_upd   (status_upd),
        .svc_req_n    (svc_req_n),
        .dbc_accept_n (dbc_accept_n),
        .in_cmd       (in_cmd),
        .fld          (fld),
        .msg_err      (msg_err),
        .svc_req      (svc_req),
        .dbc_acc      (dbc_acc)
    );

    always_comb begin
        addr_err_n = par_ok;
        sub_addr   = fld.sa;
        tx_rx      = fld.tr;
    end

    assert_own_needs_parity_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(respond) |-> $past(par_ok));
    assert_bcast_needs_enable_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(bcast) |-> $past(bcast_en));

endmodule

// File: tb/rt_cmd_decode_test.sv
module rt_cmd_decode_test;
    timeunit 1ns;
    timeprecision 1ps;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        cmd_valid = 0, own_par = 1, bcast_en = 0, word_done = 0;
    logic        msg_end = 0, status_upd = 0, illegal_n = 1, svc_req_n = 1, dbc_accept_n = 1;
    logic [15:0] cmd_word = '0;
    logic [4:0]  own_addr = 5'h0A;

    logic       in_cmd, respond, bcast, tx_rx, mode_cmd, all_words;
    logic       addr_err_n, msg_err, svc_req, dbc_acc;
    logic [4:0] sub_addr, wc_out;

    rt_cmd_decode uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .own_addr(own_addr), .own_par(own_par), .bcast_en(bcast_en),
        .word_done(word_done), .msg_end(msg_end), .status_upd(status_upd),
        .illegal_n(illegal_n), .svc_req_n(svc_req_n), .dbc_accept_n(dbc_accept_n),
        .in_cmd(in_cmd), .respond(respond), .bcast(bcast), .sub_addr(sub_addr),
        .tx_rx(tx_rx), .wc_out(wc_out), .mode_cmd(mode_cmd), .all_words(all_words),
        .addr_err_n(addr_err_n), .msg_err(msg_err), .svc_req(svc_req), .dbc_acc(dbc_acc)
    );

    typedef struct {
        logic [19:0] v;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;

    // Reference state kept from the requirements.
    logic       m_in = 0, m_resp = 0, m_bc = 0, m_tr = 0, m_merr = 0, m_srq = 0, m_dbc = 0;
    logic [4:0] m_sa = 0, m_wc = 0;
    int         m_cnt = 0;

    function automatic logic [19:0] expected();
        logic md, cnting, allw, pok;
        logic [4:0] wco;
        int   lim;
        md     = (m_sa == 5'd0) || (m_sa == 5'd31);
        cnting = m_in && !md;
        lim    = (m_wc == 0) ? 32 : int'(m_wc);
        allw   = cnting && (m_cnt == lim);
        wco    = cnting ? 5'(m_cnt) : m_wc;
        pok    = ^{own_addr, own_par};
        return {m_in, m_resp, m_bc, m_sa, m_tr, wco, md, pok, m_merr, m_srq, m_dbc, allw};
    endfunction

    task automatic step(input string tag);
        logic pok, isb, own, acc, md_old, allw_old;
        int   lim;
        exp_t e;
        @(posedge clk);
        if (rst) begin
            m_in = 0; m_resp = 0; m_bc = 0; m_tr = 0; m_sa = 0; m_wc = 0;
            m_cnt = 0; m_merr = 0; m_srq = 0; m_dbc = 0;
        end else begin
            pok = ^{own_addr, own_par};
            isb = bcast_en && (cmd_word[15:11] == 5'd31);
            own = pok && (cmd_word[15:11] == own_addr) && !isb;
            acc = cmd_valid && (isb || own);
            md_old = (m_sa == 5'd0) || (m_sa == 5'd31);
            lim = (m_wc == 0) ? 32 : int'(m_wc);
            allw_old = m_in && !md_old && (m_cnt == lim);
            if (status_upd) begin
                m_srq = !svc_req_n;
                m_dbc = !dbc_accept_n && m_in && md_old && m_tr && (m_wc == 0) && !m_merr;
            end
            if (acc) begin
                m_merr = !illegal_n;
                m_in = 1; m_resp = own; m_bc = isb;
                m_tr = cmd_word[10]; m_sa = cmd_word[9:5]; m_wc = cmd_word[4:0];
                m_cnt = 0;
            end else begin
                if (word_done && m_in && !md_old && !allw_old) m_cnt = m_cnt + 1;
                if (msg_end) begin m_in = 0; m_resp = 0; m_bc = 0; end
            end
        end
        #1;
        e.v = expected();
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        #1;
        cmd_valid = 0; word_done = 0; msg_end = 0; status_upd = 0;
    endtask

    task automatic send(input logic [4:0] rt, input logic tr, input logic [4:0] sa,
                        input logic [4:0] wc);
        cmd_word  = {rt, tr, sa, wc};
        cmd_valid = 1;
    endtask

    // Monitor: compare outputs against the queued expectation away from the edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            logic [19:0] act;
            e = q.pop_front();
            act = {in_cmd, respond, bcast, sub_addr, tx_rx, wc_out, mode_cmd,
                   addr_err_n, msg_err, svc_req, dbc_acc, all_words};
            n_vec++;
            if (act !== e.v) begin
                n_bad++;
                $display("FAIL %s actual=%05h expected=%05h", e.tag, act, e.v);
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=%0d cycles expected=finish", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk); #1;
        step("reset");
        step("reset state");
        rst = 0;
        step("R1 valid parity idle");
        own_par = 0; step("R1 parity error flagged");
        own_par = 1; step("R1 parity restored");

        send(5'h0A, 0, 5'd3, 5'd3); step("R2 own address accepted");
        step("R5 fields latched");
        word_done = 1; step("R8 count 1");
        word_done = 1; step("R7 counter shown");
        word_done = 1; step("R9 count reaches 3");
        word_done = 1; step("R9 counter holds at limit");
        msg_end = 1; step("R10 window closed, R7 field shown");

        own_par = 0;
        send(5'h0A, 1, 5'd7, 5'd9); step("R2 parity error ignores own address");
        step("R5 fields kept after ignored command");
        bcast_en = 1;
        send(5'd31, 0, 5'd4, 5'd2); step("R3 broadcast despite parity error");
        msg_end = 1; step("R10 broadcast window closed");
        own_par = 1; bcast_en = 0;
        send(5'd31, 0, 5'd6, 5'd1); step("R4 address 31 ignored with broadcast off");
        own_addr = 5'd31; own_par = 0;
        send(5'd31, 1, 5'd6, 5'd1); step("R4 address 31 answered as own");
        bcast_en = 1;
        send(5'd31, 1, 5'd8, 5'd1); step("R4 own 31 taken as broadcast when enabled");
        own_addr = 5'h0A; own_par = 1; bcast_en = 0;

        send(5'h0A, 1, 5'd0, 5'd5); step("R6 mode command subaddress 0");
        word_done = 1; step("R7 mode command shows field");
        send(5'h0A, 1, 5'd31, 5'd17); step("R6 mode command subaddress 31");

        send(5'h0A, 0, 5'd2, 5'd0); step("R9 count field 0");
        for (int i = 0; i < 31; i++) begin
            word_done = 1; step("R9 counting toward 32");
        end
        word_done = 1; step("R9 32 words reached");
        word_done = 1; step("R9 counter stays at 32");

        send(5'h0A, 0, 5'd2, 5'd4); step("R8 new command");
        word_done = 1; step("R8 count 1");
        send(5'h0A, 0, 5'd5, 5'd4); word_done = 1; step("R8 accept beats word_done");
        send(5'h0A, 1, 5'd9, 5'd6); msg_end = 1; step("R10 accept beats msg_end");

        send(5'h0A, 0, 5'd1, 5'd1); illegal_n = 0; step("R11 illegal sampled");
        illegal_n = 1; step("R11 message error held");
        send(5'h0A, 0, 5'd1, 5'd1); step("R11 legal command clears error");

        svc_req_n = 0; step("R12 no update no effect");
        status_upd = 1; step("R12 service request set");
        svc_req_n = 1; step("R12 held without update");
        status_upd = 1; step("R12 service request cleared");

        send(5'h0A, 1, 5'd0, 5'd0); step("R13 bus-control command");
        dbc_accept_n = 0; status_upd = 1; step("R13 acceptance set");
        dbc_accept_n = 1; status_upd = 1; step("R13 accept input high clears");
        send(5'h0A, 1, 5'd0, 5'd0); illegal_n = 0; step("R13 illegal bus-control command");
        illegal_n = 1; dbc_accept_n = 0; status_upd = 1; step("R13 illegal blocks acceptance");
        send(5'h0A, 1, 5'd31, 5'd2); step("R13 other mode code");
        status_upd = 1; step("R13 other mode code not accepted");
        send(5'h0A, 1, 5'd0, 5'd0); step("R13 legal again");
        status_upd = 1; send(5'h0A, 0, 5'd4, 5'd4); step("R13 update uses old command at new accept");
        msg_end = 1; step("R10 close");
        status_upd = 1; step("R13 closed window not accepted");
        dbc_accept_n = 1;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule